// File: doc/BRIEF.md
# Multi-Format Serial Line Encoder

This block drives the transmit wire of a synchronous framed serial link. An upstream framer hands it data bits one at a time over a valid/ready handshake. The block turns each bit into line symbols using one of five codes: NRZ, NRZI, FM0, FM1 or Manchester. A single shared encoder handles all five, and a 3-bit mode field picks the code at run time.

A start-of-frame strobe requests a new frame. The strobe captures the configuration inputs: line code, preamble length, preamble enable and the transmit clock edge. The frame then opens at the next byte boundary of the idle stream. It starts with 1 to 8 preamble bytes of 0x55 when the preamble is enabled, then one opening flag 0x7E, then the data bits. When no frame is active, the line carries back-to-back flags. The differential line level carries on unbroken across frame boundaries.

Each selected transition of the transmit bit clock `bclk` marks one half of a bit cell, so a bit occupies two such transitions. `bclk` is generated in the `clk` domain. A configuration bit chooses whether the falling or the rising transition of `bclk` moves the line.

Top module: `line_enc_tx`

## Requirements
- R1: After reset `line_out` is 0 and `bit_ready` is 0, and the active configuration is all zeros: NRZ, one preamble byte, preamble off, falling-edge shifting. Until a strobe arrives the line carries NRZ idle flags, whatever the configuration inputs hold.
- R2: Format code 000 (NRZ) drives the line to the bit value for the whole bit cell.
- R3: Format code 001 (NRZI) inverts the line at the start of a cell carrying 0 and leaves it unchanged for a 1. The line holds for the whole cell.
- R4: Format code 010 (FM0) inverts the line at every cell start, and inverts it again at mid-cell when the bit is 0.
- R5: Format code 011 (FM1) inverts the line at every cell start, and inverts it again at mid-cell when the bit is 1.
- R6: Format code 100 (Manchester) sends a 1 as high in the first half and low in the second, and a 0 as low then high.
- R7: Format codes 101, 110 and 111 behave exactly like NRZ.
- R8: A frame sends, in this order: (`cfg_pre_len` + 1) bytes of 0x55 when `sof_pre_en` was 1 at the strobe, then 0x7E, then the data bits. Every byte goes LSB first and no bits are stuffed. The frame opens at the first cell start after the strobe at which the idle flag byte is complete.
- R9: Idle time sends continuous 0x7E flags, LSB first. A frame ends after the data bit presented with `bit_last` = 1, and idle flags resume at the next cell. The NRZI and FM level continues from the last symbol of the previous frame.
- R10: With the active edge bit at 0, `line_out` changes only on the `clk` edge at which a falling `bclk` transition is first seen. With the bit at 1, it changes only on a rising transition. Transitions in the other direction never move the line.
- R11: The configuration inputs are captured only by a strobe that arrives while idle. Changing them at any other time has no effect on the line.
- R12: During the data phase, `bit_ready` is high for exactly one `clk` cycle at the start of each bit cell. A bit is taken when `bit_valid` is high in that cycle. If `bit_valid` is low, the cell carries a 1 and nothing is taken.
- R13: Every bit cell spans two selected `bclk` transitions. A new bit or pattern bit is chosen only on the first of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt | input | 3 | Line code select |
| cfg_pre_len | input | 3 | Preamble length minus one, in bytes |
| cfg_rise | input | 1 | 1: shift on rising `bclk`; 0: shift on falling `bclk` |
| sof | input | 1 | Start-of-frame strobe, one `clk` cycle |
| sof_pre_en | input | 1 | Send a preamble for the requested frame |
| bclk | input | 1 | Transmit bit clock, one selected transition per half cell |
| bit_in | input | 1 | Data bit |
| bit_valid | input | 1 | `bit_in` is valid |
| bit_last | input | 1 | `bit_in` is the final bit of the frame |
| bit_ready | output | 1 | Data bit accepted this cycle if valid |
| line_out | output | 1 | Encoded serial line |

## Verification
The line output updates on the `clk` edge at which a selected `bclk` transition is first seen, so it is due one `clk` edge after the transition. The bench moves `bclk` on a falling `clk` edge and reads `line_out` at the next falling edge, which puts every sample half a cycle clear of the update. `bit_ready` is combinational on the same transition, so the bench reads it just after moving `bclk`, and any transfer completes at the following rising edge. After each transition in the non-selected direction the bench waits two `clk` cycles and confirms the line has not moved. It then compares the full captured symbol stream against a code model built from the requirements.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;

    localparam int FMT_W = 3;

    localparam logic [FMT_W-1:0] FMT_NRZ  = 3'd0;
    localparam logic [FMT_W-1:0] FMT_NRZI = 3'd1;
    localparam logic [FMT_W-1:0] FMT_FM0  = 3'd2;
    localparam logic [FMT_W-1:0] FMT_FM1  = 3'd3;
    localparam logic [FMT_W-1:0] FMT_MAN  = 3'd4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PRE  = 2'd1,
        SEQ_OPEN = 2'd2,
        SEQ_DATA = 2'd3
    } seq_state_e;

endpackage

// File: rtl/line_enc_edge.sv
module line_enc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic rise_sel,
    output logic tick
);

    typedef struct packed {
        logic bclk_prev;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d = edge_q;
        edge_d.bclk_prev = bclk;
        if (rise_sel) begin
            tick = bclk & ~edge_q.bclk_prev;
        end else begin
            tick = ~bclk & edge_q.bclk_prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

endmodule

// File: rtl/line_enc_seq.sv
module line_enc_seq
    import line_enc_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter int                PRE_LEN_W = 3,
    parameter logic [BYTE_W-1:0] FLAG_PAT  = 8'h7E,
    parameter logic [BYTE_W-1:0] PRE_PAT   = 8'h55
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 sof,
    input  logic                 sof_pre_en,
    input  logic [FMT_W-1:0]     cfg_fmt,
    input  logic [PRE_LEN_W-1:0] cfg_pre_len,
    input  logic                 cfg_rise,
    input  logic                 bit_in,
    input  logic                 bit_valid,
    input  logic                 bit_last,
    output logic                 bit_ready,
    output logic                 sym_first,
    output logic                 sym_bit,
    output logic [FMT_W-1:0]     act_fmt,
    output logic                 act_rise,
    output logic                 in_frame
);

    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

    typedef struct packed {
        seq_state_e           st;
        logic [IDX_W-1:0]     idx;
        logic [PRE_LEN_W-1:0] pre_cnt;
        logic [PRE_LEN_W-1:0] pre_len;
        logic                 pre_en;
        logic                 pend;
        logic [FMT_W-1:0]     fmt;
        logic                 rise;
        logic                 phase;
        logic                 cell_bit;
    } seq_t;

    seq_t seq_d, seq_q;
    logic             cur;
    logic             byte_end;
    logic [IDX_W-1:0] idx_next;

    always_comb begin
        seq_d     = seq_q;
        cur       = seq_q.cell_bit;
        bit_ready = 1'b0;
        byte_end  = (seq_q.idx == IDX_LAST);
        idx_next  = byte_end ? '0 : seq_q.idx + 1'b1;

        // configuration is captured only from idle
        if (sof && seq_q.st == SEQ_IDLE) begin
            seq_d.pend    = 1'b1;
            seq_d.pre_en  = sof_pre_en;
            seq_d.pre_len = cfg_pre_len;
            seq_d.fmt     = cfg_fmt;
            seq_d.rise    = cfg_rise;
        end

        if (tick) begin
            seq_d.phase = ~seq_q.phase;
            if (!seq_q.phase) begin
                case (seq_q.st)
                    SEQ_IDLE: begin
                        if (seq_q.pend && seq_q.idx == '0) begin
                            seq_d.pend = 1'b0;
                            seq_d.idx  = IDX_W'(1);
                            if (seq_q.pre_en) begin
                                seq_d.st = SEQ_PRE;
                                cur      = PRE_PAT[0];
                            end else begin
                                seq_d.st = SEQ_OPEN;
                                cur      = FLAG_PAT[0];
                            end
                        end else begin
                            cur       = FLAG_PAT[seq_q.idx];
                            seq_d.idx = idx_next;
                        end
                    end
                    SEQ_PRE: begin
                        cur       = PRE_PAT[seq_q.idx];
                        seq_d.idx = idx_next;
                        if (byte_end) begin
                            seq_d.pre_cnt = seq_q.pre_cnt + 1'b1;
                            if (seq_q.pre_cnt == seq_q.pre_len) begin
                                seq_d.st      = SEQ_OPEN;
                                seq_d.pre_cnt = '0;
                            end
                        end
                    end
                    SEQ_OPEN: begin
                        cur       = FLAG_PAT[seq_q.idx];
                        seq_d.idx = idx_next;
                        if (byte_end) begin
                            seq_d.st = SEQ_DATA;
                        end
                    end
                    SEQ_DATA: begin
                        bit_ready = 1'b1;
                        if (bit_valid) begin
                            cur = bit_in;
                            if (bit_last) begin
                                seq_d.st  = SEQ_IDLE;
                                seq_d.idx = '0;
                            end
                        end else begin
                            cur = 1'b1;
                        end
                    end
                    default: seq_d.st = SEQ_IDLE;
                endcase
                seq_d.cell_bit = cur;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sym_first = ~seq_q.phase;
    assign sym_bit   = cur;
    assign act_fmt   = seq_q.fmt;
    assign act_rise  = seq_q.rise;
    assign in_frame  = (seq_q.st != SEQ_IDLE);

endmodule

// File: rtl/line_enc_sym.sv
module line_enc_sym
    import line_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             first,
    input  logic             sym_bit,
    input  logic [FMT_W-1:0] fmt,
    output logic             line
);

    typedef struct packed {
        logic lvl;
    } sym_t;

    sym_t sym_d, sym_q;

    always_comb begin
        sym_d = sym_q;
        if (tick) begin
            case (fmt)
                FMT_NRZI: if (first && !sym_bit) sym_d.lvl = ~sym_q.lvl;
                FMT_FM0:  if (first || !sym_bit) sym_d.lvl = ~sym_q.lvl;
                FMT_FM1:  if (first || sym_bit)  sym_d.lvl = ~sym_q.lvl;
                FMT_MAN:  sym_d.lvl = first ? sym_bit : ~sym_bit;
                default:  if (first) sym_d.lvl = sym_bit;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_q <= '0;
        end else begin
            sym_q <= sym_d;
        end
    end

    assign line = sym_q.lvl;

endmodule

// File: rtl/line_enc_tx.sv
module line_enc_tx
    import line_enc_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter int                PRE_LEN_W = 3,
    parameter logic [BYTE_W-1:0] FLAG_PAT  = 8'h7E,
    parameter logic [BYTE_W-1:0] PRE_PAT   = 8'h55
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FMT_W-1:0]     cfg_fmt,
    input  logic [PRE_LEN_W-1:0] cfg_pre_len,
    input  logic                 cfg_rise,
    input  logic                 sof,
    input  logic                 sof_pre_en,
    input  logic                 bclk,
    input  logic                 bit_in,
    input  logic                 bit_valid,
    input  logic                 bit_last,
    output logic                 bit_ready,
    output logic                 line_out
);

    logic             tick;
    logic             sym_first;
    logic             sym_bit;
    logic [FMT_W-1:0] act_fmt;
    logic             act_rise;
    logic             in_frame;

    line_enc_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .rise_sel (act_rise),
        .tick     (tick)
    );

    line_enc_seq #(
        .BYTE_W    (BYTE_W),
        .PRE_LEN_W (PRE_LEN_W),
        .FLAG_PAT  (FLAG_PAT),
        .PRE_PAT   (PRE_PAT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .sof         (sof),
        .sof_pre_en  (sof_pre_en),
        .cfg_fmt     (cfg_fmt),
        .cfg_pre_len (cfg_pre_len),
        .cfg_rise    (cfg_rise),
        .bit_in      (bit_in),
        .bit_valid   (bit_valid),
        .bit_last    (bit_last),
        .bit_ready   (bit_ready),
        .sym_first   (sym_first),
        .sym_bit     (sym_bit),
        .act_fmt     (act_fmt),
        .act_rise    (act_rise),
        .in_frame    (in_frame)
    );

    line_enc_sym u_sym (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .first   (sym_first),
        .sym_bit (sym_bit),
        .fmt     (act_fmt),
        .line    (line_out)
    );

endmodule

// File: rtl/line_enc_chk.sv
module line_enc_chk
    import line_enc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             first,
    input logic             sym_bit,
    input logic [FMT_W-1:0] act_fmt,
    input logic             in_frame,
    input logic             bit_ready,
    input logic             line_out
);

    // R10: the line moves only on a selected bclk transition
    p_hold_between_ticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(line_out));

    // R12: ready is offered only at the start of a cell
    p_ready_at_cell_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ready |-> (tick && first));

    p_nrz_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && first && act_fmt == FMT_NRZ) |=> (line_out == $past(sym_bit)));

    p_nrzi_one_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && first && act_fmt == FMT_NRZI && sym_bit) |=> $stable(line_out));

    // R4 and R5: both FM codes invert at every cell start
    p_fm_cell_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && first && (act_fmt == FMT_FM0 || act_fmt == FMT_FM1))
        |=> (line_out != $past(line_out)));

    p_man_second_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !first && act_fmt == FMT_MAN) |=> (line_out == !$past(sym_bit)));

    p_fmt_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |=> $stable(act_fmt));

endmodule

bind line_enc_tx line_enc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .first     (sym_first),
    .sym_bit   (sym_bit),
    .act_fmt   (act_fmt),
    .in_frame  (in_frame),
    .bit_ready (bit_ready),
    .line_out  (line_out)
);

// File: tb/line_enc_tx_test.sv
`timescale 1ns/1ps
module line_enc_tx_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg_fmt;
    logic [2:0] cfg_pre_len;
    logic       cfg_rise;
    logic       sof;
    logic       sof_pre_en;
    logic       bclk;
    logic       bit_in;
    logic       bit_valid;
    logic       bit_last;
    logic       bit_ready;
    logic       line_out;

    always #2 clk = ~clk;

    line_enc_tx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_fmt     (cfg_fmt),
        .cfg_pre_len (cfg_pre_len),
        .cfg_rise    (cfg_rise),
        .sof         (sof),
        .sof_pre_en  (sof_pre_en),
        .bclk        (bclk),
        .bit_in      (bit_in),
        .bit_valid   (bit_valid),
        .bit_last    (bit_last),
        .bit_ready   (bit_ready),
        .line_out    (line_out)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    bit   exp_b [0:255];
    int   nexp;
    bit   dat   [0:63];
    bit   dlst  [0:63];
    int   ndat;
    int   ev_sof;
    int   ev_cfg;
    logic [2:0] ev_cfg_val;
    logic sym [0:511];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_plan();
        nexp = 0; ndat = 0; ev_sof = -1; ev_cfg = -1; ev_cfg_val = 3'd0;
    endtask

    task automatic push_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            exp_b[nexp] = v[i]; nexp++;
        end
    endtask

    task automatic push_ones(input int n);
        for (int i = 0; i < n; i++) begin
            exp_b[nexp] = 1'b1; nexp++;
        end
    endtask

    task automatic push_data(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            dat[ndat] = v[i]; dlst[ndat] = (i == n - 1); ndat++;
            exp_b[nexp] = v[i]; nexp++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_fmt = '0; cfg_pre_len = '0; cfg_rise = 1'b0;
        sof = 1'b0; sof_pre_en = 1'b0; bclk = 1'b0;
        bit_in = 1'b0; bit_valid = 1'b0; bit_last = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_sof();
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
    endtask

    task automatic drive_feed(input int k, input int gapleft);
        bit_valid = (gapleft == 0) && (k < ndat);
        bit_in    = (k < ndat) ? dat[k]  : 1'b0;
        bit_last  = (k < ndat) ? dlst[k] : 1'b0;
    endtask

    // Runs the planned stream and compares every half-cell symbol
    task automatic run_stream(input string req, input logic [2:0] fmt, input logic rise,
                              input logic pre_en, input logic [2:0] plen, input bit do_sof,
                              input int gap, input logic [2:0] model_fmt);
        int   k = 0;
        int   gapleft = gap;
        int   mis = 0;
        int   stab = 0;
        int   bad_at = -1;
        logic prev;
        logic lvl;
        logic s0, s1;
        do_reset();
        cfg_fmt = fmt; cfg_rise = rise; cfg_pre_len = plen; sof_pre_en = pre_en;
        if (do_sof) pulse_sof();
        drive_feed(k, gapleft);
        prev = line_out;
        for (int b = 0; b < nexp; b++) begin
            for (int h = 0; h < 2; h++) begin
                if (h == 0 && b == ev_sof) pulse_sof();
                if (h == 0 && b == ev_cfg) cfg_fmt = ev_cfg_val;
                bclk = rise ? 1'b0 : 1'b1;
                repeat (2) @(negedge clk);
                if (line_out !== prev) stab++;
                bclk = rise ? 1'b1 : 1'b0;
                #1;
                if (bit_ready === 1'b1) begin
                    if (bit_valid) k++;
                    else if (gapleft > 0) gapleft--;
                end
                @(negedge clk);
                sym[2*b+h] = line_out;
                prev = line_out;
                drive_feed(k, gapleft);
            end
        end
        lvl = 1'b0;
        for (int b = 0; b < nexp; b++) begin
            case (model_fmt)
                3'd1: begin
                    if (!exp_b[b]) lvl = ~lvl;
                    s0 = lvl; s1 = lvl;
                end
                3'd2: begin
                    lvl = ~lvl; s0 = lvl;
                    if (!exp_b[b]) lvl = ~lvl;
                    s1 = lvl;
                end
                3'd3: begin
                    lvl = ~lvl; s0 = lvl;
                    if (exp_b[b]) lvl = ~lvl;
                    s1 = lvl;
                end
                3'd4: begin
                    s0 = exp_b[b]; s1 = ~exp_b[b]; lvl = s1;
                end
                default: begin
                    s0 = exp_b[b]; s1 = exp_b[b]; lvl = s1;
                end
            endcase
            if (sym[2*b] !== s0 || sym[2*b+1] !== s1) begin
                mis++;
                if (bad_at < 0) bad_at = b;
            end
        end
        if (bad_at >= 0)
            $display("  first mismatching bit cell %0d: actual %b%b expected bit %0d",
                     bad_at, sym[2*bad_at], sym[2*bad_at+1], exp_b[bad_at]);
        check(mis == 0, req, "mismatching bit cells", mis, 0);
        check(stab == 0, "R10", "line changes after non-selected edge", stab, 0);
        check(k == ndat, "R12", "data bits taken", k, ndat);
    endtask

    task automatic t_reset();
        do_reset();
        check(line_out === 1'b0, "R1", "line_out after reset", int'(line_out), 0);
        check(bit_ready === 1'b0, "R1", "bit_ready after reset", int'(bit_ready), 0);
        // no strobe: FM0 on the inputs must not take effect (R1, R11)
        clear_plan();
        push_byte(8'h7E); push_byte(8'h7E);
        run_stream("R1", 3'b010, 1'b0, 1'b0, 3'd0, 1'b0, 0, 3'd0);
    endtask

    task automatic t_nrz();
        clear_plan();
        push_byte(8'h7E); push_data(16'h01A3, 11); push_byte(8'h7E);
        run_stream("R2", 3'b000, 1'b0, 1'b0, 3'd0, 1'b1, 0, 3'd0);
    endtask

    task automatic t_nrzi();
        clear_plan();
        push_byte(8'h55); push_byte(8'h7E); push_data(16'h00C5, 9); push_byte(8'h7E);
        run_stream("R3", 3'b001, 1'b0, 1'b1, 3'd0, 1'b1, 0, 3'd1);
    endtask

    task automatic t_fm0();
        clear_plan();
        push_byte(8'h7E); push_data(16'h5A3C, 16); push_byte(8'h7E);
        run_stream("R4", 3'b010, 1'b0, 1'b0, 3'd0, 1'b1, 0, 3'd2);
    endtask

    task automatic t_fm1();
        clear_plan();
        push_byte(8'h55); push_byte(8'h7E); push_data(16'h0F31, 13); push_byte(8'h7E);
        run_stream("R5", 3'b011, 1'b0, 1'b1, 3'd0, 1'b1, 0, 3'd3);
    endtask

    task automatic t_man();
        clear_plan();
        push_byte(8'h7E); push_data(16'h00B6, 10); push_byte(8'h7E);
        run_stream("R6", 3'b100, 1'b0, 1'b0, 3'd0, 1'b1, 0, 3'd4);
    endtask

    task automatic t_reserved();
        clear_plan();
        push_byte(8'h7E); push_data(16'h0093, 8); push_byte(8'h7E);
        run_stream("R7", 3'b110, 1'b0, 1'b0, 3'd0, 1'b1, 0, 3'd0);
        clear_plan();
        push_byte(8'h7E); push_data(16'h0036, 7); push_byte(8'h7E);
        run_stream("R7", 3'b111, 1'b0, 1'b0, 3'd0, 1'b1, 0, 3'd0);
    endtask

    task automatic t_pre8();
        clear_plan();
        for (int i = 0; i < 8; i++) push_byte(8'h55);
        push_byte(8'h7E); push_data(16'h002D, 6); push_byte(8'h7E);
        run_stream("R8", 3'b000, 1'b0, 1'b1, 3'd7, 1'b1, 0, 3'd0);
        clear_plan();
        push_byte(8'h55); push_byte(8'h55); push_byte(8'h55);
        push_byte(8'h7E); push_data(16'h0005, 4); push_byte(8'h7E);
        run_stream("R8", 3'b100, 1'b0, 1'b1, 3'd2, 1'b1, 0, 3'd4);
    endtask

    task automatic t_rise();
        clear_plan();
        push_byte(8'h7E); push_data(16'h0139, 9); push_byte(8'h7E);
        run_stream("R10", 3'b010, 1'b1, 1'b0, 3'd0, 1'b1, 0, 3'd2);
    endtask

    task automatic t_cfg_mid();
        clear_plan();
        push_byte(8'h7E); push_data(16'h3C96, 14); push_byte(8'h7E);
        ev_cfg = 12; ev_cfg_val = 3'b000;
        run_stream("R11", 3'b011, 1'b0, 1'b0, 3'd0, 1'b1, 0, 3'd3);
    endtask

    task automatic t_two_frames();
        clear_plan();
        push_byte(8'h7E); push_data(16'h0032, 6);
        push_byte(8'h7E);                 // idle flag, strobe at its fourth bit
        push_byte(8'h7E); push_data(16'h0013, 5); push_byte(8'h7E);
        ev_sof = 17;
        run_stream("R9", 3'b001, 1'b0, 1'b0, 3'd0, 1'b1, 0, 3'd1);
    endtask

    task automatic t_gap();
        clear_plan();
        push_byte(8'h7E); push_ones(3); push_data(16'h0024, 6); push_byte(8'h7E);
        run_stream("R12", 3'b000, 1'b0, 1'b0, 3'd0, 1'b1, 3, 3'd0);
    endtask

    initial begin
        t_reset();
        t_nrz();
        t_nrzi();
        t_fm0();
        t_fm1();
        t_man();
        t_reserved();
        t_pre8();      // R8 and R13 framing
        t_rise();
        t_cfg_mid();
        t_two_frames();
        t_gap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule